// File: doc/BRIEF.md
# Dual-Divider SPI Master with Register Access

This block is an SPI master driven through a small word-addressed register slave. The slave is zero-wait: an access with strobe high is acknowledged in the same cycle, and read data is combinational. Software first sets a configuration word and a transfer word. The configuration word holds the clock polarity flag and two clock dividers, one for output bits and one for input bits. The transfer word holds the chip-select mask and two bit counts. A write to the data word then launches a frame.

Each frame runs in order: a two-cycle preparation step, a settle wait of one output-bit period, an output phase that shifts the data word out MSB first, and an input phase that samples the MISO line. Chip select stays asserted through the whole frame. While a frame is running, a data write fills a one-word pending slot. When the current transfer ends, the pending word starts its output phase at once. There is no further preparation, and chip select stays low.

State machine: `ST_IDLE` goes to `ST_PREP` on a data write. `ST_PREP` goes to `ST_SETTLE` after 2 cycles. `ST_SETTLE` goes to `ST_WRITE`, `ST_READ`, `ST_IDLE`, or back to itself (when a zero-length pending word is taken) after the write-divider count. `ST_WRITE` goes to `ST_READ`, or ends the transfer after its last bit. `ST_READ` ends the transfer after its last bit. At the end of a transfer the machine re-enters the first non-empty phase if a word is pending, and otherwise returns to `ST_IDLE`.

Top module: `spi_bus_master`

## Requirements
- R1: After reset, all chip-select lines are high, SCK and MOSI are low, the data and transfer words read 0, and the configuration word reads 0x00400400 (both divider fields hold 4, i.e. divider 6).
- R2: Word address 1 reads back the transfer word as written: mask in bits 15:0, output bit count in 23:16, input bit count in 31:24. Word address 2 reads the polarity flag in bit 0, the output divider minus two in bits 15:8, the input divider minus two in bits 27:20, busy in bit 30 and overflow in bit 31.
- R3: The first rising SCK edge (relative to the idle level) of a frame falls in frame cycle 2 + wdiv + ceil(d/2), where cycle 0 is the first cycle after the launching write and d is the divider of the first non-empty phase.
- R4: In the output phase, bits 31, 30, ... of the data word appear on MOSI, one per wdiv cycles. MOSI changes only while SCK is at its idle level. SCK is low for ceil(div/2) cycles and high for the rest of each bit.
- R5: In the input phase, MISO is sampled on each rising SCK edge. After the last bit, the data word reads the sampled bits right-aligned (last bit in bit 0, zeros above). A frame with no input bits leaves the previous value.
- R6: A frame keeps busy high and the masked chip-select lines low for exactly 2 + wdiv + wlen*wdiv + rlen*rdiv cycles.
- R7: Busy reads 1 from the launching write until the frame ends.
- R8: A data write one cycle after a launch is held pending. It starts right after the previous transfer with no preparation, and chip select stays low between the two.
- R9: A data write while a word is already pending is dropped, and it sets overflow (bit 31). Any configuration write clears overflow.
- R10: With both bit counts zero, the frame lasts 2 + wdiv cycles and SCK does not toggle.
- R11: With configuration bit 0 set, SCK idles high and all its edges are inverted.
- R12: The input phase uses the input divider and the output phase uses the output divider, independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_adr | input | 2 | Word address (0 data, 1 transfer, 2 configuration) |
| bus_dat_w | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_stb | input | 1 | Access strobe |
| bus_ack | output | 1 | Acknowledge, same cycle as strobe |
| bus_dat_r | output | 32 | Read data |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |

## Verification
The hardest case to reach is a write that lands while the pending slot is already full. The stimulus gets there by issuing three data writes on three consecutive cycles, all while the preparation step is still running. The bench then checks that only two transfers are shifted, with chip select held low across both, and that the overflow bit is set and then cleared by a configuration write. The one-cycle divider on the input side, where the sample edge and the bit end fall in the same cycle, is reached through a vector with input divider 2.

// File: rtl/spi_bm_pkg.sv
`timescale 1ns/1ps
package spi_bm_pkg;
    localparam int ADR_DATA = 0;
    localparam int ADR_XFER = 1;
    localparam int ADR_CFG  = 2;
    localparam int CNT_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SETTLE,
        ST_WRITE,
        ST_READ
    } spi_state_e;
endpackage

// File: rtl/spi_bm_bittimer.sv
`timescale 1ns/1ps
module spi_bm_bittimer #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          bit_end,
    output logic          rise,
    output logic          sck_hi
);
    logic [DW-1:0] cnt;
    logic [DW-1:0] half;

    assign half    = (div + DW'(1)) >> 1;
    assign bit_end = run && (cnt == div - DW'(1));
    assign rise    = run && (cnt == half);
    assign sck_hi  = run && (cnt >= half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || bit_end) cnt <= '0;
        else                     cnt <= cnt + DW'(1);
    end

    AST_BIT_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bit_end) |=> !sck_hi); // R4
endmodule

// File: rtl/spi_bm_regs.sv
`timescale 1ns/1ps
module spi_bm_regs
    import spi_bm_pkg::*;
#(
    parameter int DIVW    = 8,
    parameter int DIV_RST = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      adr,
    input  logic [31:0]     dat_w,
    input  logic            we,
    input  logic            stb,
    output logic [31:0]     dat_r,
    input  logic            busy,
    input  logic            take,
    input  logic [31:0]     rx_data,
    output logic            launch,
    output logic            pend_valid,
    output logic [31:0]     pend_data,
    output logic [7:0]      flags,
    output logic [DIVW-1:0] wdivm2,
    output logic [DIVW-1:0] rdivm2,
    output logic [31:0]     xfer
);
    localparam logic [DIVW-1:0] DIVM2_RST = DIVW'(DIV_RST - 2);

    logic        ovf;
    logic        dwr, xwr, cwr;
    logic [31:0] cfg_rd;

    assign dwr    = stb && we && (adr == 2'(ADR_DATA));
    assign xwr    = stb && we && (adr == 2'(ADR_XFER));
    assign cwr    = stb && we && (adr == 2'(ADR_CFG));
    assign launch = dwr && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags  <= '0;
            wdivm2 <= DIVM2_RST;
            rdivm2 <= DIVM2_RST;
            xfer   <= '0;
        end else begin
            if (cwr) begin
                flags  <= dat_w[7:0];
                wdivm2 <= dat_w[8 +: DIVW];
                rdivm2 <= dat_w[20 +: DIVW];
            end
            if (xwr) xfer <= dat_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_data  <= '0;
            ovf        <= 1'b0;
        end else begin
            if (take) pend_valid <= 1'b0;
            if (dwr && busy) begin
                if (!pend_valid || take) begin
                    pend_valid <= 1'b1;
                    pend_data  <= dat_w;
                end else begin
                    ovf <= 1'b1;
                end
            end
            if (cwr) ovf <= 1'b0;
        end
    end

    always_comb begin
        cfg_rd               = '0;
        cfg_rd[7:0]          = flags;
        cfg_rd[8 +: DIVW]    = wdivm2;
        cfg_rd[20 +: DIVW]   = rdivm2;
        cfg_rd[30]           = busy;
        cfg_rd[31]           = ovf;
        unique case (adr)
            2'(ADR_DATA): dat_r = rx_data;
            2'(ADR_XFER): dat_r = xfer;
            2'(ADR_CFG):  dat_r = cfg_rd;
            default:      dat_r = '0;
        endcase
    end

    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr && busy && pend_valid && !take && !cwr) |=> ovf); // R9
    AST_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend_valid); // R8
endmodule

// File: rtl/spi_bm_fsm.sv
`timescale 1ns/1ps
module spi_bm_fsm
    import spi_bm_pkg::*;
#(
    parameter int NCS  = 4,
    parameter int DIVW = 8,
    localparam int DW  = DIVW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic [31:0]     launch_data,
    input  logic            pend_valid,
    input  logic [31:0]     pend_data,
    input  logic            cpol,
    input  logic [DIVW-1:0] wdivm2,
    input  logic [DIVW-1:0] rdivm2,
    input  logic [NCS-1:0]  cs_mask,
    input  logic [CNT_W-1:0] wlen,
    input  logic [CNT_W-1:0] rlen,
    input  logic            miso,
    input  logic            bit_end,
    input  logic            rise,
    input  logic            sck_hi,
    output logic            take,
    output logic            busy,
    output logic            run,
    output logic [DW-1:0]   cur_div,
    output logic            sck,
    output logic            mosi,
    output logic [NCS-1:0]  cs_n,
    output logic [31:0]     rx_data
);
    spi_state_e state, state_n;

    logic [DW-1:0]    wdiv, rdiv, wait_cnt;
    logic [CNT_W-1:0] bits_left, bits_val;
    logic [31:0]      tx, rx, rx_nx;
    logic wait_clr, bits_ld, bits_dec, tx_ld, tx_from_pend, tx_shift;
    logic rx_clr, rx_commit, frame_end, body_start;

    assign wdiv    = DW'(wdivm2) + DW'(2);
    assign rdiv    = DW'(rdivm2) + DW'(2);
    assign run     = (state == ST_WRITE) || (state == ST_READ);
    assign cur_div = (state == ST_READ) ? rdiv : wdiv;
    assign busy    = (state != ST_IDLE);
    assign rx_nx   = ((state == ST_READ) && rise) ? {rx[30:0], miso} : rx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state and control
    always_comb begin
        state_n      = state;
        wait_clr     = 1'b0;
        bits_ld      = 1'b0;
        bits_val     = '0;
        bits_dec     = 1'b0;
        tx_ld        = 1'b0;
        tx_from_pend = 1'b0;
        tx_shift     = 1'b0;
        rx_clr       = 1'b0;
        rx_commit    = 1'b0;
        frame_end    = 1'b0;
        body_start   = 1'b0;
        take         = 1'b0;
        unique case (state)
            ST_IDLE: if (launch) begin
                state_n  = ST_PREP;
                tx_ld    = 1'b1;
                wait_clr = 1'b1;
            end
            ST_PREP: if (wait_cnt == DW'(1)) begin
                state_n  = ST_SETTLE;
                wait_clr = 1'b1;
            end
            ST_SETTLE: if (wait_cnt == wdiv - DW'(1)) begin
                if (wlen == '0 && rlen == '0) frame_end  = 1'b1;
                else                          body_start = 1'b1;
            end
            ST_WRITE: if (bit_end) begin
                tx_shift = 1'b1;
                bits_dec = 1'b1;
                if (bits_left == CNT_W'(1)) begin
                    if (rlen != '0) begin
                        state_n  = ST_READ;
                        bits_ld  = 1'b1;
                        bits_val = rlen;
                        rx_clr   = 1'b1;
                    end else begin
                        frame_end = 1'b1;
                    end
                end
            end
            ST_READ: if (bit_end) begin
                bits_dec = 1'b1;
                if (bits_left == CNT_W'(1)) begin
                    rx_commit = 1'b1;
                    frame_end = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (frame_end) begin
            if (pend_valid) begin
                take         = 1'b1;
                tx_ld        = 1'b1;
                tx_from_pend = 1'b1;
                body_start   = 1'b1;
            end else begin
                state_n = ST_IDLE;
            end
        end
        if (body_start) begin
            if (wlen != '0) begin
                state_n  = ST_WRITE;
                bits_ld  = 1'b1;
                bits_val = wlen;
            end else if (rlen != '0) begin
                state_n  = ST_READ;
                bits_ld  = 1'b1;
                bits_val = rlen;
                rx_clr   = 1'b1;
            end else begin
                state_n  = ST_SETTLE;
                wait_clr = 1'b1;
            end
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt  <= '0;
            bits_left <= '0;
            tx        <= '0;
            rx        <= '0;
            rx_data   <= '0;
        end else begin
            if (wait_clr) wait_cnt <= '0;
            else if (state == ST_PREP || state == ST_SETTLE) wait_cnt <= wait_cnt + DW'(1);

            if (bits_ld)       bits_left <= bits_val;
            else if (bits_dec) bits_left <= bits_left - CNT_W'(1);

            if (tx_ld)         tx <= tx_from_pend ? pend_data : launch_data;
            else if (tx_shift) tx <= {tx[30:0], 1'b0};

            rx <= rx_clr ? '0 : rx_nx;
            if (rx_commit) rx_data <= rx_nx;
        end
    end

    // outputs
    always_comb begin
        sck  = cpol ^ sck_hi;
        mosi = (state == ST_WRITE) && tx[31];
        cs_n = busy ? ~cs_mask : '1;
    end

    AST_PHASE_HAS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (bits_left != '0)); // R5
endmodule

// File: rtl/spi_bus_master.sv
`timescale 1ns/1ps
module spi_bus_master
    import spi_bm_pkg::*;
#(
    parameter int NCS     = 4,
    parameter int DIVW    = 8,
    parameter int DIV_RST = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     bus_adr,
    input  logic [31:0]    bus_dat_w,
    input  logic           bus_we,
    input  logic           bus_stb,
    output logic           bus_ack,
    output logic [31:0]    bus_dat_r,
    output logic           spi_sck,
    output logic           spi_mosi,
    input  logic           spi_miso,
    output logic [NCS-1:0] spi_cs_n
);
    localparam int DW = DIVW + 1;

    logic            busy, take, launch, pend_valid, run;
    logic            bit_end, rise, sck_hi;
    logic [31:0]     pend_data, rx_data, xfer;
    logic [7:0]      flags;
    logic [DIVW-1:0] wdivm2, rdivm2;
    logic [DW-1:0]   cur_div;

    assign bus_ack = bus_stb;

    spi_bm_regs #(.DIVW(DIVW), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .adr(bus_adr), .dat_w(bus_dat_w),
        .we(bus_we), .stb(bus_stb), .dat_r(bus_dat_r), .busy(busy),
        .take(take), .rx_data(rx_data), .launch(launch),
        .pend_valid(pend_valid), .pend_data(pend_data), .flags(flags),
        .wdivm2(wdivm2), .rdivm2(rdivm2), .xfer(xfer)
    );

    spi_bm_fsm #(.NCS(NCS), .DIVW(DIVW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_data(bus_dat_w),
        .pend_valid(pend_valid), .pend_data(pend_data), .cpol(flags[0]),
        .wdivm2(wdivm2), .rdivm2(rdivm2), .cs_mask(xfer[NCS-1:0]),
        .wlen(xfer[23:16]), .rlen(xfer[31:24]), .miso(spi_miso),
        .bit_end(bit_end), .rise(rise), .sck_hi(sck_hi), .take(take),
        .busy(busy), .run(run), .cur_div(cur_div), .sck(spi_sck),
        .mosi(spi_mosi), .cs_n(spi_cs_n), .rx_data(rx_data)
    );

    spi_bm_bittimer #(.DW(DW)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .div(cur_div),
        .bit_end(bit_end), .rise(rise), .sck_hi(sck_hi)
    );

    logic sck_norm;
    assign sck_norm = spi_sck ^ flags[0];

    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&spi_cs_n)); // R6
    AST_IDLE_SCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_norm); // R11
    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sck_norm && $past(sck_norm)) |-> $stable(spi_mosi)); // R4
endmodule

// File: tb/test_spi_bus_master.sv
`timescale 1ns/1ps
module test_spi_bus_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  adr = '0;
    logic [31:0] dat_w = '0;
    logic        we = 1'b0, stb = 1'b0;
    logic        ack;
    logic [31:0] dat_r;
    logic        sck, mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_n;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    spi_bus_master i_spi_bus_master (
        .clk(clk), .rst_n(rst_n), .bus_adr(adr), .bus_dat_w(dat_w),
        .bus_we(we), .bus_stb(stb), .bus_ack(ack), .bus_dat_r(dat_r),
        .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
    );

    localparam int NV = 5;
    localparam int          V_CPOL [NV] = '{0, 0, 1, 0, 1};
    localparam int          V_WD   [NV] = '{6, 2, 3, 7, 4};
    localparam int          V_RD   [NV] = '{6, 5, 4, 2, 9};
    localparam int          V_WL   [NV] = '{8, 16, 12, 0, 32};
    localparam int          V_RL   [NV] = '{8, 4, 0, 32, 24};
    localparam int          V_MASK [NV] = '{5, 2, 8, 1, 15};
    localparam logic [31:0] V_DATA [NV] = '{32'hA500_0000, 32'h81F7_0000,
                                           32'h5A30_0000, 32'h0000_0000, 32'h1234_5678};
    localparam logic [31:0] V_PAT  [NV] = '{32'h0000_003C, 32'h0000_000B,
                                           32'h0000_0000, 32'hDEAD_BEEF, 32'h00C0_FFEE};

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        adr = a; dat_w = d; we = 1'b1; stb = 1'b1;
        @(negedge clk);
        we = 1'b0; stb = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        adr = a; we = 1'b0; stb = 1'b1;
        #1 d = dat_r;
        stb = 1'b0;
    endtask

    task automatic set_miso(input int falls, input int wl, input int rl, input logic [31:0] pat);
        int pos, k;
        miso = 1'b0;
        if (wl + rl > 0) begin
            pos = falls % (wl + rl);
            k = pos - wl;
            if (k >= 0) miso = pat[rl - 1 - k];
        end
    endtask

    // Launches a frame with nw consecutive data writes and observes it to its end.
    task automatic run_frame(input int nw, input logic [31:0] w0, w1, w2,
                             input int wl, rl, input logic [31:0] pat, input logic cp,
                             output int cyc, output int rises, output int first_rise,
                             output int cs_low, output int cs_gap,
                             output logic [63:0] mcap, output logic [3:0] cs_seen);
        int sent, falls;
        logic prev, sn, bsy;
        sent = 1; cyc = 0; rises = 0; falls = 0; first_rise = -1;
        cs_low = 0; cs_gap = 0; mcap = '0; prev = 1'b0; cs_seen = 4'hF;
        set_miso(0, wl, rl, pat);
        @(negedge clk);
        adr = 2'd0; dat_w = w0; we = 1'b1; stb = 1'b1;
        for (int g = 0; g < 20000; g++) begin
            @(negedge clk);
            adr = 2'd2; we = 1'b0; stb = 1'b1;
            #1 bsy = dat_r[30];
            if (!bsy) break;
            sn = sck ^ cp;
            if (sn && !prev) begin
                if (first_rise < 0) first_rise = cyc;
                rises++;
                mcap = {mcap[62:0], mosi};
            end
            if (!sn && prev) falls++;
            prev = sn;
            if (cs_n != 4'hF) begin cs_low++; cs_seen = cs_n; end
            else cs_gap++;
            cyc++;
            set_miso(falls, wl, rl, pat);
            if (sent < nw) begin
                adr = 2'd0; we = 1'b1; dat_w = (sent == 1) ? w1 : w2;
                sent++;
            end
        end
        stb = 1'b0; we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd, exp_rx;
        logic [63:0] mcap, emos;
        logic [3:0]  cs_seen;
        int cyc, rises, fr, csl, gap, d;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 cs_n", 64'(cs_n), 64'hF);
        chk("R1 sck", 64'(sck), 64'h0);
        chk("R1 mosi", 64'(mosi), 64'h0);
        bus_rd(2'd2, rd); chk("R1 config word", 64'(rd), 64'h0040_0400);
        bus_rd(2'd0, rd); chk("R1 data word", 64'(rd), 64'h0);
        bus_rd(2'd1, rd); chk("R1 transfer word", 64'(rd), 64'h0);

        // Table walk: R2 R3 R4 R5 R6 R11 R12
        exp_rx = '0;
        for (int v = 0; v < NV; v++) begin
            bus_wr(2'd2, 32'(V_CPOL[v]) | (32'(V_WD[v] - 2) << 8) | (32'(V_RD[v] - 2) << 20));
            bus_wr(2'd1, 32'(V_MASK[v]) | (32'(V_WL[v]) << 16) | (32'(V_RL[v]) << 24));
            bus_rd(2'd2, rd);
            chk("R2 config readback", 64'(rd),
                64'(32'(V_CPOL[v]) | (32'(V_WD[v] - 2) << 8) | (32'(V_RD[v] - 2) << 20)));
            bus_rd(2'd1, rd);
            chk("R2 transfer readback", 64'(rd),
                64'(32'(V_MASK[v]) | (32'(V_WL[v]) << 16) | (32'(V_RL[v]) << 24)));
            chk("R11 idle sck level", 64'(sck), 64'(V_CPOL[v]));
            run_frame(1, V_DATA[v], 32'h0, 32'h0, V_WL[v], V_RL[v], V_PAT[v],
                      V_CPOL[v] != 0, cyc, rises, fr, csl, gap, mcap, cs_seen);
            chk("R6 R12 frame cycles", 64'(cyc),
                64'(2 + V_WD[v] + V_WL[v] * V_WD[v] + V_RL[v] * V_RD[v]));
            chk("R6 chip select low cycles", 64'(csl), 64'(cyc));
            chk("R6 chip select lines", 64'(cs_seen), 64'(~V_MASK[v] & 4'hF));
            chk("R4 R5 sck rising edges", 64'(rises), 64'(V_WL[v] + V_RL[v]));
            d = (V_WL[v] > 0) ? V_WD[v] : V_RD[v];
            chk("R3 first rising edge cycle", 64'(fr), 64'(2 + V_WD[v] + (d + 1) / 2));
            emos = (V_WL[v] == 0) ? 64'h0 : (64'(V_DATA[v]) >> (32 - V_WL[v]));
            emos = emos << V_RL[v];
            chk("R4 mosi bit stream", mcap, emos);
            if (V_RL[v] == 32)     exp_rx = V_PAT[v];
            else if (V_RL[v] > 0)  exp_rx = V_PAT[v] & ((32'h1 << V_RL[v]) - 32'h1);
            bus_rd(2'd0, rd);
            chk("R5 received word", 64'(rd), 64'(exp_rx));
            chk("R11 sck back at idle", 64'(sck), 64'(V_CPOL[v]));
        end

        // R10 both counts zero
        bus_wr(2'd2, 32'(5 - 2) << 8);
        bus_wr(2'd1, 32'h0000_0001);
        run_frame(1, 32'hFFFF_FFFF, 32'h0, 32'h0, 0, 0, 32'h0, 1'b0,
                  cyc, rises, fr, csl, gap, mcap, cs_seen);
        chk("R10 empty frame cycles", 64'(cyc), 64'd7);
        chk("R10 no sck edges", 64'(rises), 64'd0);
        chk("R10 chip select low cycles", 64'(csl), 64'd7);
        bus_rd(2'd0, rd);
        chk("R5 data kept after empty frame", 64'(rd), 64'(exp_rx));

        // R7 R8 chained pair
        bus_wr(2'd2, (32'(4 - 2) << 8) | (32'(3 - 2) << 20));
        bus_wr(2'd1, 32'h0003 | (32'd8 << 16) | (32'd4 << 24));
        run_frame(2, 32'hC300_0000, 32'h7E00_0000, 32'h0, 8, 4, 32'h9, 1'b0,
                  cyc, rises, fr, csl, gap, mcap, cs_seen);
        chk("R8 R7 chained busy cycles", 64'(cyc), 64'd94);
        chk("R8 chained rising edges", 64'(rises), 64'd24);
        chk("R8 no chip select gap", 64'(gap), 64'd0);
        chk("R8 chained mosi stream", mcap, 64'hC3_07E0);
        bus_rd(2'd0, rd);
        chk("R8 received word of second transfer", 64'(rd), 64'h9);
        bus_rd(2'd2, rd);
        chk("R9 no overflow on single pending", 64'(rd[31]), 64'h0);
        chk("R7 busy clear after frame", 64'(rd[30]), 64'h0);

        // R9 overflow: third word dropped
        run_frame(3, 32'hC300_0000, 32'h7E00_0000, 32'hFF00_0000, 8, 4, 32'h9, 1'b0,
                  cyc, rises, fr, csl, gap, mcap, cs_seen);
        chk("R9 dropped word not shifted (cycles)", 64'(cyc), 64'd94);
        chk("R9 dropped word not shifted (mosi)", mcap, 64'hC3_07E0);
        bus_rd(2'd2, rd);
        chk("R9 overflow set", 64'(rd[31]), 64'h1);
        bus_wr(2'd2, (32'(4 - 2) << 8) | (32'(3 - 2) << 20));
        bus_rd(2'd2, rd);
        chk("R9 overflow cleared by config write", 64'(rd[31]), 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule